// File: doc/BRIEF.md
# Ramp Test Pattern Inserter with Output Bit-Depth Formatting

This block sits at the end of a video datapath that carries two pixels per clock (an odd tap and an even tap, 12 bits each). When the pattern is off, it passes the sensor pixels through. When the pattern is on, it puts a synthetic ramp in place of those pixels. The ramp follows the line-valid and frame-valid timing that arrives with the pixels.

There are two ramp variants:
- **Fixed:** every line starts at code 960 and climbs by one code per clock.
- **Sliding:** the start code of every line moves up by two on each new frame.

The output bit-depth reduction (12, 10 or 8 bits) is the only processing that comes after the selector, so it acts on sensor data and pattern alike. All outputs are registered. The line-valid and frame-valid signals are delayed by one clock so they stay aligned with the pixels.

Top module: `ramp_pattern_inserter`

## Requirements
- R1: With pattern mode 2'b00 or 2'b11, each output tap carries its own sensor input tap, after bit-depth formatting.
- R2: With pattern mode 2'b01 (fixed), both taps carry the same value. That value is 960 on the first clock of a line (the first clock with line-valid high after it was low) and rises by one on each following line-valid clock.
- R3: Every line-valid rising edge restarts the ramp at the line's start code, so all lines of a frame are identical.
- R4: With pattern mode 2'b10 (sliding), a line starts at 960 + 2·k. Here k counts the frame-valid rising edges since reset that came before the current frame. The first frame after reset uses k = 0. Frames are counted in every mode.
- R5: The generated value wraps modulo 4096.
- R6: The format select chooses the output depth:
  - 2'b00 or 2'b11 passes all 12 bits.
  - 2'b01 outputs value[11:2] in bits [9:0], with bits [11:10] zero.
  - 2'b10 outputs value[11:4] in bits [7:0], with bits [11:8] zero.
- R7: Outputs appear one clock after their inputs. The line-valid and frame-valid outputs equal their inputs delayed by one clock.
- R8: A synchronous active-high reset clears all outputs and restarts the sliding frame count at zero.
- R9: In the fixed and sliding modes, both taps output zero while line-valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_odd_i | input | 12 | Sensor odd-tap pixel |
| pix_even_i | input | 12 | Sensor even-tap pixel |
| lval_i | input | 1 | Line valid in |
| fval_i | input | 1 | Frame valid in |
| pat_mode_i | input | 2 | Pattern mode: 00 pass, 01 fixed, 10 sliding, 11 pass |
| depth_sel_i | input | 2 | Output depth: 00 12-bit, 01 10-bit, 10 8-bit, 11 12-bit |
| pix_odd_o | output | 12 | Formatted odd-tap pixel |
| pix_even_o | output | 12 | Formatted even-tap pixel |
| lval_o | output | 1 | Line valid, one clock delayed |
| fval_o | output | 1 | Frame valid, one clock delayed |

## Verification
A wrong line counter shows up on the first output pixel of the next line, one clock after line-valid rises, because the start code is wrong there. A slip in the frame offset shows in the sliding mode at the first line of the affected frame, as a start code that differs by a multiple of two. A wrong format path shows at once, as nonzero upper bits or a mis-shifted value on the very next output. Long lines reveal wrap errors only at the clock where the ramp passes 4095.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    PAT_PASS     = 2'b00,
    PAT_FIXED    = 2'b01,
    PAT_SLIDE    = 2'b10,
    PAT_PASS_ALT = 2'b11
  } pat_mode_e;

  typedef enum logic [1:0] {
    DEPTH_12     = 2'b00,
    DEPTH_10     = 2'b01,
    DEPTH_8      = 2'b10,
    DEPTH_12_ALT = 2'b11
  } depth_e;
endpackage

// File: rtl/tpg_ramp_gen.sv
module tpg_ramp_gen #(
  parameter int PIX_W      = 12,
  parameter int START_CODE = 960,
  parameter int SLIDE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lval_i,
  input  logic             fval_i,
  input  logic             slide_en,
  output logic [PIX_W-1:0] ramp_o
);
  localparam logic [PIX_W-1:0] START_W = PIX_W'(START_CODE);
  localparam logic [PIX_W-1:0] STEP_W  = PIX_W'(SLIDE_STEP);

  logic             lval_d, fval_d;
  logic [PIX_W-1:0] cnt_q, frame_off_q, next_off_q;
  logic             lval_rise, fval_rise;
  logic [PIX_W-1:0] off_cur, line_start;

  assign lval_rise  = lval_i & ~lval_d;
  assign fval_rise  = fval_i & ~fval_d;
  // offset in force for the frame that is starting or running
  assign off_cur    = fval_rise ? next_off_q : frame_off_q;
  assign line_start = START_W + (slide_en ? off_cur : '0);
  assign ramp_o     = lval_rise ? line_start : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lval_d      <= 1'b0;
      fval_d      <= 1'b0;
      cnt_q       <= '0;
      frame_off_q <= '0;
      next_off_q  <= '0;
    end else begin
      lval_d <= lval_i;
      fval_d <= fval_i;
      if (fval_rise) begin
        frame_off_q <= next_off_q;
        next_off_q  <= next_off_q + STEP_W;
      end
      if (lval_i) cnt_q <= ramp_o + 1'b1;
    end
  end
endmodule

// File: rtl/tpg_depth_fmt.sv
module tpg_depth_fmt
  import tpg_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int LANES = 2
) (
  input  logic [LANES*PIX_W-1:0] din,
  input  logic [1:0]             depth_sel,
  output logic [LANES*PIX_W-1:0] dout
);
  localparam int DROP10 = PIX_W - 10;
  localparam int DROP8  = PIX_W - 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PIX_W-1:0] lane_in, lane_out;
    assign lane_in = din[g*PIX_W +: PIX_W];
    always_comb begin
      case (depth_e'(depth_sel))
        DEPTH_10: lane_out = lane_in >> DROP10;
        DEPTH_8:  lane_out = lane_in >> DROP8;
        default:  lane_out = lane_in;
      endcase
    end
    assign dout[g*PIX_W +: PIX_W] = lane_out;
  end
endmodule

// File: rtl/ramp_pattern_inserter.sv
module ramp_pattern_inserter
  import tpg_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int START_CODE = 960,
  parameter int SLIDE_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_odd_i,
  input  logic [PIX_W-1:0] pix_even_i,
  input  logic             lval_i,
  input  logic             fval_i,
  input  logic [1:0]       pat_mode_i,
  input  logic [1:0]       depth_sel_i,
  output logic [PIX_W-1:0] pix_odd_o,
  output logic [PIX_W-1:0] pix_even_o,
  output logic             lval_o,
  output logic             fval_o
);
  localparam int LANES = 2;

  logic [PIX_W-1:0]       ramp;
  logic                   pat_on;
  logic [PIX_W-1:0]       pat_val;
  logic [LANES*PIX_W-1:0] sel_bus, fmt_bus;

  assign pat_on = (pat_mode_e'(pat_mode_i) == PAT_FIXED) ||
                  (pat_mode_e'(pat_mode_i) == PAT_SLIDE);

  tpg_ramp_gen #(
    .PIX_W     (PIX_W),
    .START_CODE(START_CODE),
    .SLIDE_STEP(SLIDE_STEP)
  ) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .lval_i  (lval_i),
    .fval_i  (fval_i),
    .slide_en(pat_mode_e'(pat_mode_i) == PAT_SLIDE),
    .ramp_o  (ramp)
  );

  assign pat_val = lval_i ? ramp : '0;
  assign sel_bus = pat_on ? {pat_val, pat_val} : {pix_even_i, pix_odd_i};

  tpg_depth_fmt #(
    .PIX_W(PIX_W),
    .LANES(LANES)
  ) u_fmt (
    .din      (sel_bus),
    .depth_sel(depth_sel_i),
    .dout     (fmt_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_odd_o  <= '0;
      pix_even_o <= '0;
      lval_o     <= 1'b0;
      fval_o     <= 1'b0;
    end else begin
      pix_odd_o  <= fmt_bus[0 +: PIX_W];
      pix_even_o <= fmt_bus[PIX_W +: PIX_W];
      lval_o     <= lval_i;
      fval_o     <= fval_i;
    end
  end
endmodule

// File: rtl/tpg_ramp_chk.sv
module tpg_ramp_chk #(
  parameter int PIX_W      = 12,
  parameter int START_CODE = 960
) (
  input logic             clk,
  input logic             rst,
  input logic [PIX_W-1:0] pix_odd_i,
  input logic             lval_i,
  input logic             fval_i,
  input logic [1:0]       pat_mode_i,
  input logic [1:0]       depth_sel_i,
  input logic [PIX_W-1:0] pix_odd_o,
  input logic [PIX_W-1:0] pix_even_o,
  input logic             lval_o,
  input logic             fval_o
);
  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lval_o == $past(lval_i)) && (fval_o == $past(fval_i)));

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_mode_i == 2'b00 && depth_sel_i == 2'b00) |=> pix_odd_o == $past(pix_odd_i));

  // R2
  taps_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_mode_i == 2'b01 || pat_mode_i == 2'b10) |=> pix_odd_o == pix_even_o);

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lval_i && $past(lval_i) && pat_mode_i == 2'b01 && $past(pat_mode_i) == 2'b01 &&
     depth_sel_i == 2'b00 && $past(depth_sel_i) == 2'b00)
    |=> pix_odd_o == $past(pix_odd_o) + 1'b1);

  // R3
  line_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(lval_i) && pat_mode_i == 2'b01 && depth_sel_i == 2'b00)
    |=> pix_odd_o == PIX_W'(START_CODE));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (depth_sel_i == 2'b10) |=> (pix_odd_o[PIX_W-1:8] == '0) && (pix_even_o[PIX_W-1:8] == '0));

  // R9
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!lval_i && (pat_mode_i == 2'b01 || pat_mode_i == 2'b10)) |=> pix_odd_o == '0);
endmodule

bind ramp_pattern_inserter tpg_ramp_chk #(
  .PIX_W     (PIX_W),
  .START_CODE(START_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pix_odd_i  (pix_odd_i),
  .lval_i     (lval_i),
  .fval_i     (fval_i),
  .pat_mode_i (pat_mode_i),
  .depth_sel_i(depth_sel_i),
  .pix_odd_o  (pix_odd_o),
  .pix_even_o (pix_even_o),
  .lval_o     (lval_o),
  .fval_o     (fval_o)
);

// File: tb/test_ramp_pattern_inserter.sv
`timescale 1ns/1ps
module test_ramp_pattern_inserter;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] pix_odd_i, pix_even_i;
  logic        lval_i, fval_i;
  logic [1:0]  pat_mode_i, depth_sel_i;
  logic [11:0] pix_odd_o, pix_even_o;
  logic        lval_o, fval_o;

  always #4 clk = ~clk;

  ramp_pattern_inserter i_ramp_pattern_inserter (
    .clk(clk), .rst(rst),
    .pix_odd_i(pix_odd_i), .pix_even_i(pix_even_i),
    .lval_i(lval_i), .fval_i(fval_i),
    .pat_mode_i(pat_mode_i), .depth_sel_i(depth_sel_i),
    .pix_odd_o(pix_odd_o), .pix_even_o(pix_even_o),
    .lval_o(lval_o), .fval_o(fval_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int frame_idx = 0;

  logic        pend_chk = 1'b0;
  logic        pend_lv, pend_fv;
  logic [11:0] pend_odd, pend_even;
  string       pend_tag;

  // {mode, depth} per frame
  localparam logic [3:0] VEC [8] = '{
    4'b00_00, 4'b01_00, 4'b10_00, 4'b10_00,
    4'b01_01, 4'b10_10, 4'b11_00, 4'b00_10
  };

  function automatic logic [11:0] fmt(input logic [11:0] v, input logic [1:0] d);
    case (d)
      2'b01:   return v >> 2;
      2'b10:   return v >> 4;
      default: return v;
    endcase
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic fv, input logic [11:0] so, input logic [11:0] se,
                      input logic [1:0] m, input logic [1:0] d, input logic chk,
                      input logic [11:0] eo, input logic [11:0] ee, input string tg);
    @(negedge clk);
    if (pend_chk) begin
      check({pend_tag, " odd"}, pix_odd_o, pend_odd);
      check({pend_tag, " even"}, pix_even_o, pend_even);
      check("R7 lval", {11'd0, lval_o}, {11'd0, pend_lv});
      check("R7 fval", {11'd0, fval_o}, {11'd0, pend_fv});
    end
    lval_i = lv; fval_i = fv; pix_odd_i = so; pix_even_i = se;
    pat_mode_i = m; depth_sel_i = d;
    pend_chk = chk; pend_lv = lv; pend_fv = fv;
    pend_odd = eo; pend_even = ee; pend_tag = tg;
  endtask

  task automatic drive_frame(input logic [1:0] m, input logic [1:0] d, input int nl, input int w);
    logic        pat = (m == 2'b01) || (m == 2'b10);
    logic [11:0] off = (m == 2'b10) ? 12'((frame_idx * 2) % 4096) : 12'd0;
    logic [11:0] so, se, v;
    string       tg;
    for (int g = 0; g < 2; g++) begin
      so = 12'(g * 77 + 1234); se = 12'(4000 - g * 13);
      step(1'b0, 1'b1, so, se, m, d, 1'b1,
           pat ? 12'd0 : fmt(so, d), pat ? 12'd0 : fmt(se, d), pat ? "R9" : "R1");
    end
    for (int l = 0; l < nl; l++) begin
      for (int i = 0; i < w; i++) begin
        so = 12'((i * 37 + l * 5 + 5) & 12'hfff);
        se = 12'((i * 91 + 2000) & 12'hfff);
        v  = 12'(960 + off + 12'(i));
        if (w > 1000)            tg = "R5";
        else if (d != 2'b00)     tg = "R6";
        else if (m == 2'b10)     tg = "R4";
        else if (pat && l > 0)   tg = "R3";
        else if (pat)            tg = "R2";
        else                     tg = "R1";
        step(1'b1, 1'b1, so, se, m, d, 1'b1,
             pat ? fmt(v, d) : fmt(so, d), pat ? fmt(v, d) : fmt(se, d), tg);
      end
      for (int g = 0; g < 2; g++)
        step(1'b0, 1'b1, 12'd55, 12'd66, m, d, 1'b1,
             pat ? 12'd0 : fmt(12'd55, d), pat ? 12'd0 : fmt(12'd66, d), pat ? "R9" : "R1");
    end
    for (int g = 0; g < 2; g++)
      step(1'b0, 1'b0, 12'd7, 12'd9, m, d, 1'b1,
           pat ? 12'd0 : fmt(12'd7, d), pat ? 12'd0 : fmt(12'd9, d), pat ? "R9" : "R1");
    frame_idx++;
  endtask

  task automatic do_reset();
    step(1'b0, 1'b0, 12'd0, 12'd0, 2'b00, 2'b00, 1'b0, 12'd0, 12'd0, "");
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R8: outputs cleared while reset is held
    check("R8 odd", pix_odd_o, 12'd0);
    check("R8 even", pix_even_o, 12'd0);
    check("R8 valid", {10'd0, lval_o, fval_o}, 12'd0);
    rst = 1'b0;
    pend_chk = 1'b0;
    frame_idx = 0;
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none
    rst = 1'b1; lval_i = 0; fval_i = 0; pix_odd_i = 0; pix_even_i = 0;
    pat_mode_i = 0; depth_sel_i = 0;
    do_reset();
    for (int k = 0; k < 8; k++)
      drive_frame(VEC[k][3:2], VEC[k][1:0], 2, 20);
    // R4: sliding counted across frames in other modes
    drive_frame(2'b10, 2'b00, 2, 12);
    // R5: long fixed line wraps past 4095
    drive_frame(2'b01, 2'b00, 1, 3200);
    // R8: sliding offset restarts after reset
    do_reset();
    drive_frame(2'b10, 2'b00, 1, 8);
    drive_frame(2'b10, 2'b00, 1, 8);
    step(1'b0, 1'b0, 12'd0, 12'd0, 2'b00, 2'b00, 1'b0, 12'd0, 12'd0, "");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule